// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block holds the volume and mute settings for a two-channel audio gain stage and decides the clock edge on which each new setting reaches that stage. Software writes a 7-bit volume code per channel and one control word. The control word carries a general mute bit and a mode bit. With the mode bit clear, settings go through at once. With it set, each channel waits for the next zero crossing of its own signed sample stream before it changes gain or general mute state. A sign change between accepted samples, or a sample of exactly zero, counts as a zero crossing.

Each channel has its own sign-change detector and its own armed slot. A second write to a channel that still has a value armed pushes the armed value out first and arms the new one. This keeps a slow or silent signal from stalling a run of writes. A write of a mute code takes effect at once in either mode. Any later change away from mute goes through crossing timing again. Setting the mode bit to 0 releases everything that is still armed.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset both gain outputs read 88 and both mute flags are 1. No volume change and no general mute change is pending, and the first sample accepted after reset has no predecessor.
- R2: Codes 0 to 87 are gain steps from +16 dB down to -71 dB, with code 0 the loudest, and leave the channel's mute flag low. Codes 88 to 127 drive that channel's mute flag high. The gain output always shows the applied code itself.
- R3: With the mode bit 0, a volume write appears on the addressed channel's gain output on the clock edge that takes the write. wr_sel 0 addresses left, 1 addresses right and 2 addresses the control word.
- R4: With the mode bit 1, a gain-step write is armed and the gain output holds its old value. The armed code appears on the second rising edge after a crossing sample is presented on that channel.
- R5: A crossing on a channel is a valid sample that is zero, or whose sign bit differs from that channel's previous valid sample. A nonzero first sample after reset is not a crossing.
- R6: A write to a channel that already has a code armed applies the armed code on that edge and arms the new code.
- R7: A write of a mute code (88 or above) takes effect on the edge that takes the write in either mode and drops any armed code. A later write of a gain step while muted follows R3 or R4.
- R8: Left and right detect crossings independently. A crossing on one channel never applies the other channel's armed state.
- R9: The control word uses bit 0 for general mute and bit 1 for the zero-cross mode. With the mode bit 0, both mute flags follow the general mute bit on the second edge after the control write. While general mute is 1, both flags stay high whatever the codes.
- R10: With the mode bit 1, a change of general mute reaches each channel's mute flag only at that channel's own crossing, with the R4 timing.
- R11: Writing the mode bit to 0 applies every armed volume code and every pending general mute change on the second edge after the control write.
- R12: A write with wr_sel 3 changes no output and no stored setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 2 | Write target: 0 left volume, 1 right volume, 2 control, 3 none |
| wr_data | input | CODE_W (7) | Volume code, or control word {mode, general mute} in bits 1:0 |
| smp_valid | input | 1 | Both sample inputs carry a new sample |
| smp_l | input | SAMPLE_W (16) | Left signed sample |
| smp_r | input | SAMPLE_W (16) | Right signed sample |
| gain_l | output | CODE_W (7) | Applied left volume code |
| gain_r | output | CODE_W (7) | Applied right volume code |
| mute_l | output | 1 | Left channel muted |
| mute_r | output | 1 | Right channel muted |

## Verification
A lost or stale armed code shows up on a gain output no later than the second edge after the next crossing sample or the next write to that channel. A corrupted detector history shows up as a gain change one sample early or one sample late. A crossing routed to the wrong channel moves the other channel's gain or mute flag within two edges, so the stimulus gives the two channels different crossing histories. General mute state that is per channel can hide an error until the first crossing after a control write. For that reason, each mute flag is checked after each channel's own crossing.

// File: rtl/zcg_pkg.sv
`timescale 1ns/1ps
package zcg_pkg;
   typedef enum logic [1:0] {
      SEL_LEFT  = 2'd0,
      SEL_RIGHT = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_NONE  = 2'd3
   } wsel_e;

   // control word bit positions
   localparam int CTRL_GMUTE_BIT = 0;
   localparam int CTRL_ZCMODE_BIT = 1;

   localparam int NUM_CH = 2;
endpackage

// File: rtl/zcg_cross_det.sv
`timescale 1ns/1ps
module zcg_cross_det #(
   parameter int SAMPLE_W      = 16,
   parameter bit ZERO_IS_CROSS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld,
   input  logic [SAMPLE_W-1:0] smp,
   output logic                zc_o
);
   localparam int SIGN_BIT = SAMPLE_W - 1;

   logic prev_sign_q;
   logic prev_vld_q;
   logic zc_q;
   logic sign_flip;
   logic is_zero;
   logic hit;

   assign sign_flip = prev_vld_q && (smp[SIGN_BIT] != prev_sign_q);

   generate
      if (ZERO_IS_CROSS) begin : g_zero_cross
         assign is_zero = (smp == '0);
      end else begin : g_sign_only
         assign is_zero = 1'b0;
      end
   endgenerate

   assign hit = smp_vld && (sign_flip || is_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sign_q <= 1'b0;
         prev_vld_q  <= 1'b0;
         zc_q        <= 1'b0;
      end else begin
         zc_q <= hit;
         if (smp_vld) begin
            prev_sign_q <= smp[SIGN_BIT];
            prev_vld_q  <= 1'b1;
         end
      end
   end

   assign zc_o = zc_q;
endmodule

// File: rtl/zcg_ctrl_reg.sv
`timescale 1ns/1ps
module zcg_ctrl_reg
   import zcg_pkg::*;
#(
   parameter int CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [CODE_W-1:0] wr_data,
   output logic              zc_mode_o,
   output logic              gm_tgt_o
);
   logic zc_mode_q;
   logic gm_tgt_q;
   logic ctrl_hit;

   assign ctrl_hit = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zc_mode_q <= 1'b0;
         gm_tgt_q  <= 1'b0;
      end else if (ctrl_hit) begin
         zc_mode_q <= wr_data[CTRL_ZCMODE_BIT];
         gm_tgt_q  <= wr_data[CTRL_GMUTE_BIT];
      end
   end

   assign zc_mode_o = zc_mode_q;
   assign gm_tgt_o  = gm_tgt_q;
endmodule

// File: rtl/zcg_chan_seq.sv
`timescale 1ns/1ps
module zcg_chan_seq #(
   parameter int CODE_W    = 7,
   parameter int MUTE_CODE = 88
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              zc_mode,
   input  logic              gm_tgt,
   input  logic              zc,
   output logic [CODE_W-1:0] gain_o,
   output logic              mute_o
);
   localparam logic [CODE_W-1:0] MUTE_C = CODE_W'(MUTE_CODE);

   logic [CODE_W-1:0] app_q;
   logic [CODE_W-1:0] arm_q;
   logic              arm_vld_q;
   logic              gm_app_q;
   logic              wr_is_mute;
   logic              release_now;

   assign wr_is_mute  = (wr_code >= MUTE_C);
   assign release_now = !zc_mode || zc;

   // volume path: applied code and one armed slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         app_q     <= MUTE_C;
         arm_q     <= MUTE_C;
         arm_vld_q <= 1'b0;
      end else if (wr_hit) begin
         if (wr_is_mute || !zc_mode) begin
            app_q     <= wr_code;
            arm_vld_q <= 1'b0;
         end else begin
            if (arm_vld_q) begin
               app_q <= arm_q;
            end
            arm_q     <= wr_code;
            arm_vld_q <= 1'b1;
         end
      end else if (arm_vld_q && release_now) begin
         app_q     <= arm_q;
         arm_vld_q <= 1'b0;
      end
   end

   // general mute image for this channel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gm_app_q <= 1'b0;
      end else if ((gm_app_q != gm_tgt) && release_now) begin
         gm_app_q <= gm_tgt;
      end
   end

   assign gain_o = app_q;
   assign mute_o = gm_app_q || (app_q >= MUTE_C);
endmodule

// File: rtl/zc_gain_ctrl.sv
`timescale 1ns/1ps
module zc_gain_ctrl
   import zcg_pkg::*;
#(
   parameter int CODE_W        = 7,
   parameter int MUTE_CODE     = 88,
   parameter int SAMPLE_W      = 16,
   parameter bit ZERO_IS_CROSS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [CODE_W-1:0]   wr_data,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_l,
   input  logic [SAMPLE_W-1:0] smp_r,
   output logic [CODE_W-1:0]   gain_l,
   output logic [CODE_W-1:0]   gain_r,
   output logic                mute_l,
   output logic                mute_r
);
   localparam int CODE_SPAN = 1 << CODE_W;

   generate
      if (CODE_W < 2) begin : g_bad_code_w
         $error("zc_gain_ctrl: CODE_W must hold the control word");
      end
      if (MUTE_CODE < 1 || MUTE_CODE >= CODE_SPAN) begin : g_bad_mute
         $error("zc_gain_ctrl: MUTE_CODE outside the code range");
      end
      if (SAMPLE_W < 2) begin : g_bad_smp_w
         $error("zc_gain_ctrl: SAMPLE_W too small for a signed sample");
      end
   endgenerate

   logic                               zc_mode;
   logic                               gm_tgt;
   logic [NUM_CH-1:0]                  zc_pulse;
   logic [NUM_CH-1:0][SAMPLE_W-1:0]    smp_arr;
   logic [NUM_CH-1:0][CODE_W-1:0]      gain_arr;
   logic [NUM_CH-1:0]                  mute_arr;

   assign smp_arr[0] = smp_l;
   assign smp_arr[1] = smp_r;

   zcg_ctrl_reg #(
      .CODE_W (CODE_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .zc_mode_o (zc_mode),
      .gm_tgt_o  (gm_tgt)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic wr_hit;
         assign wr_hit = wr_en && (wr_sel == 2'(ch));

         zcg_cross_det #(
            .SAMPLE_W      (SAMPLE_W),
            .ZERO_IS_CROSS (ZERO_IS_CROSS)
         ) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_vld (smp_valid),
            .smp     (smp_arr[ch]),
            .zc_o    (zc_pulse[ch])
         );

         zcg_chan_seq #(
            .CODE_W    (CODE_W),
            .MUTE_CODE (MUTE_CODE)
         ) u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit),
            .wr_code (wr_data),
            .zc_mode (zc_mode),
            .gm_tgt  (gm_tgt),
            .zc      (zc_pulse[ch]),
            .gain_o  (gain_arr[ch]),
            .mute_o  (mute_arr[ch])
         );
      end
   endgenerate

   assign gain_l = gain_arr[0];
   assign gain_r = gain_arr[1];
   assign mute_l = mute_arr[0];
   assign mute_r = mute_arr[1];
endmodule

// File: rtl/zcg_chk.sv
`timescale 1ns/1ps
module zcg_chk #(
   parameter int CODE_W    = 7,
   parameter int MUTE_CODE = 88
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [CODE_W-1:0] wr_data,
   input logic [CODE_W-1:0] gain_l,
   input logic [CODE_W-1:0] gain_r,
   input logic              mute_l,
   input logic              mute_r,
   input logic              zc_mode,
   input logic              gm_tgt,
   input logic [1:0]        zc_pulse
);
   localparam logic [CODE_W-1:0] MUTE_C = CODE_W'(MUTE_CODE);

   // R3: forced mode write lands on the next edge
   p_forced_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0 && !zc_mode) |=> (gain_l == $past(wr_data)));

   // R7: a mute code goes straight through in either mode
   p_mute_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && wr_data >= MUTE_C) |=> (mute_r && gain_r == $past(wr_data)));

   // R4: in crossing mode the left gain holds without a write or a crossing
   p_hold_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (zc_mode && !(wr_en && wr_sel == 2'd0) && !zc_pulse[0]) |=> $stable(gain_l));

   // R8: right channel holds on its own, whatever the left does
   p_hold_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (zc_mode && !(wr_en && wr_sel == 2'd1) && !zc_pulse[1]) |=> $stable(gain_r));

   // R9: forced general mute covers both channels
   p_gm_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!zc_mode && gm_tgt) |=> (mute_l && mute_r));

   // R10: left mute flag waits for a left crossing while its code is a gain step
   p_gm_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (zc_mode && !zc_pulse[0] && !(wr_en && wr_sel == 2'd0) && gain_l < MUTE_C)
      |=> $stable(mute_l));

   // R12: a write with no target leaves the control settings alone
   p_no_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=> ($stable(zc_mode) && $stable(gm_tgt)));
endmodule

bind zc_gain_ctrl zcg_chk #(
   .CODE_W    (CODE_W),
   .MUTE_CODE (MUTE_CODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .gain_l   (gain_l),
   .gain_r   (gain_r),
   .mute_l   (mute_l),
   .mute_r   (mute_r),
   .zc_mode  (zc_mode),
   .gm_tgt   (gm_tgt),
   .zc_pulse (zc_pulse)
);

// File: tb/zc_gain_ctrl_tb_top.sv
`timescale 1ns/1ps
module zc_gain_ctrl_tb_top;
   localparam int CW = 7;
   localparam int SW = 16;
   localparam int NV = 26;
   localparam int VW = 63;

   typedef struct packed {
      logic [1:0]    op;   // 0 write, 1 sample
      logic [1:0]    sel;
      logic [CW-1:0] dat;
      logic [SW-1:0] sl;
      logic [SW-1:0] sr;
      logic [CW-1:0] gl;
      logic [CW-1:0] gr;
      logic          ml;
      logic          mr;
      logic [3:0]    rq;
   } vec_t;

   // op sel data smp_l smp_r | gain_l gain_r mute_l mute_r | requirement
   localparam logic [VW-1:0] VEC [NV] = '{
      {2'd0,2'd2,7'd0 ,16'h0000,16'h0000, 7'd88,7'd88,1'b1,1'b1, 4'd9 },  // R9 forced, no mute
      {2'd0,2'd0,7'd10,16'h0000,16'h0000, 7'd10,7'd88,1'b0,1'b1, 4'd3 },  // R3
      {2'd0,2'd1,7'd20,16'h0000,16'h0000, 7'd10,7'd20,1'b0,1'b0, 4'd8 },  // R8
      {2'd0,2'd2,7'd2 ,16'h0000,16'h0000, 7'd10,7'd20,1'b0,1'b0, 4'd4 },  // R4 enter crossing mode
      {2'd0,2'd0,7'd30,16'h0000,16'h0000, 7'd10,7'd20,1'b0,1'b0, 4'd4 },  // R4 armed
      {2'd1,2'd0,7'd0 ,16'h0064,16'h0064, 7'd10,7'd20,1'b0,1'b0, 4'd5 },  // R5 first sample
      {2'd1,2'd0,7'd0 ,16'hFFCE,16'h0005, 7'd30,7'd20,1'b0,1'b0, 4'd4 },  // R4 left crosses
      {2'd0,2'd1,7'd40,16'h0000,16'h0000, 7'd30,7'd20,1'b0,1'b0, 4'd4 },  // R4
      {2'd0,2'd1,7'd50,16'h0000,16'h0000, 7'd30,7'd40,1'b0,1'b0, 4'd6 },  // R6
      {2'd1,2'd0,7'd0 ,16'hFFFD,16'h0007, 7'd30,7'd40,1'b0,1'b0, 4'd5 },  // R5 no crossing
      {2'd1,2'd0,7'd0 ,16'hFFFD,16'hFFFF, 7'd30,7'd50,1'b0,1'b0, 4'd8 },  // R8 right only
      {2'd0,2'd0,7'd87,16'h0000,16'h0000, 7'd30,7'd50,1'b0,1'b0, 4'd4 },  // R4
      {2'd1,2'd0,7'd0 ,16'h0000,16'hFFFF, 7'd87,7'd50,1'b0,1'b0, 4'd2 },  // R2 zero sample, -71 dB
      {2'd0,2'd0,7'd95,16'h0000,16'h0000, 7'd95,7'd50,1'b1,1'b0, 4'd7 },  // R7
      {2'd0,2'd0,7'd0 ,16'h0000,16'h0000, 7'd95,7'd50,1'b1,1'b0, 4'd7 },  // R7 un-mute waits
      {2'd1,2'd0,7'd0 ,16'h0005,16'hFFFF, 7'd95,7'd50,1'b1,1'b0, 4'd5 },  // R5 zero to positive
      {2'd1,2'd0,7'd0 ,16'hFFFB,16'hFFFE, 7'd0 ,7'd50,1'b0,1'b0, 4'd5 },  // R5
      {2'd0,2'd2,7'd3 ,16'h0000,16'h0000, 7'd0 ,7'd50,1'b0,1'b0, 4'd10},  // R10 armed mute
      {2'd1,2'd0,7'd0 ,16'h0007,16'hFFFE, 7'd0 ,7'd50,1'b1,1'b0, 4'd10},  // R10 left
      {2'd1,2'd0,7'd0 ,16'h0007,16'h0003, 7'd0 ,7'd50,1'b1,1'b1, 4'd10},  // R10 right
      {2'd0,2'd2,7'd2 ,16'h0000,16'h0000, 7'd0 ,7'd50,1'b1,1'b1, 4'd10},  // R10 un-mute armed
      {2'd0,2'd0,7'd40,16'h0000,16'h0000, 7'd0 ,7'd50,1'b1,1'b1, 4'd4 },  // R4
      {2'd0,2'd2,7'd0 ,16'h0000,16'h0000, 7'd40,7'd50,1'b0,1'b0, 4'd11},  // R11
      {2'd0,2'd3,7'd5 ,16'h0000,16'h0000, 7'd40,7'd50,1'b0,1'b0, 4'd12},  // R12
      {2'd0,2'd2,7'd1 ,16'h0000,16'h0000, 7'd40,7'd50,1'b1,1'b1, 4'd9 },  // R9
      {2'd0,2'd2,7'd0 ,16'h0000,16'h0000, 7'd40,7'd50,1'b0,1'b0, 4'd9 }   // R9
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd0;
   logic [CW-1:0] wr_data = '0;
   logic          smp_valid = 1'b0;
   logic [SW-1:0] smp_l = '0;
   logic [SW-1:0] smp_r = '0;
   logic [CW-1:0] gain_l, gain_r;
   logic          mute_l, mute_r;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   zc_gain_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .smp_valid (smp_valid),
      .smp_l     (smp_l),
      .smp_r     (smp_r),
      .gain_l    (gain_l),
      .gain_r    (gain_r),
      .mute_l    (mute_l),
      .mute_r    (mute_r)
   );

   task automatic check(input int rq, input logic [CW-1:0] gl, input logic [CW-1:0] gr,
                        input logic ml, input logic mr);
      n_chk++;
      if (gain_l !== gl || gain_r !== gr || mute_l !== ml || mute_r !== mr) begin
         n_bad++;
         $display("FAIL R%0d: got gain %0d/%0d mute %0b/%0b, expected gain %0d/%0d mute %0b/%0b",
                  rq, gain_l, gain_r, mute_l, mute_r, gl, gr, ml, mr);
      end
   endtask

   // one operation for one cycle, then settle two more edges
   task automatic do_op(input logic [1:0] op, input logic [1:0] sel, input logic [CW-1:0] dat,
                        input logic [SW-1:0] sl, input logic [SW-1:0] sr);
      @(negedge clk);
      if (op == 2'd0) begin
         wr_en = 1'b1; wr_sel = sel; wr_data = dat;
      end else begin
         smp_valid = 1'b1; smp_l = sl; smp_r = sr;
      end
      @(negedge clk);
      wr_en = 1'b0; smp_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      check(1, 7'd88, 7'd88, 1'b1, 1'b1);        // R1 while in reset
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 7'd88, 7'd88, 1'b1, 1'b1);        // R1 after release

      for (int i = 0; i < NV; i++) begin
         v = vec_t'(VEC[i]);
         do_op(v.op, v.sel, v.dat, v.sl, v.sr);
         check(int'(v.rq), v.gl, v.gr, v.ml, v.mr);
      end

      // R1: reset mid-run clears applied and armed state and sample history
      do_op(2'd0, 2'd2, 7'd2, '0, '0);
      do_op(2'd0, 2'd0, 7'd12, '0, '0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(1, 7'd88, 7'd88, 1'b1, 1'b1);
      rst_n = 1'b1;
      do_op(2'd0, 2'd2, 7'd2, '0, '0);
      do_op(2'd0, 2'd0, 7'd5, '0, '0);
      check(4, 7'd88, 7'd88, 1'b1, 1'b1);        // R4 armed from mute
      do_op(2'd1, 2'd0, '0, 16'hFFF9, 16'h0004);
      check(5, 7'd88, 7'd88, 1'b1, 1'b1);        // R5 no predecessor after reset
      do_op(2'd1, 2'd0, '0, 16'h0007, 16'h0004);
      check(5, 7'd5, 7'd88, 1'b0, 1'b1);         // R5 first real crossing
      // R12 in crossing mode: sel 3 does not release the armed right code
      do_op(2'd0, 2'd1, 7'd9, '0, '0);
      do_op(2'd0, 2'd3, 7'd0, '0, '0);
      check(12, 7'd5, 7'd88, 1'b0, 1'b1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule